// File: doc/BRIEF.md
# HDLC Transmit Bit-Stuffing Serializer

This block turns a stream of frame bytes into the serial bit stream of a bit-oriented synchronous link. Bytes arrive on a valid/ready interface, with a marker on the final byte of each frame. Each bit goes out on `txBit` in one slot of the bit clock. A bit slot is one clock cycle in which `bitEn` is high. Each data bit also feeds a CRC-16 generator. After the last byte, the complemented CRC follows as the frame check sequence. A closing flag then ends the frame.

Zero insertion applies to every bit of the data bytes and of the check sequence. After five ones in a row, a zero is placed in the next slot, and the byte shifter waits for that slot. Flag octets bypass the stuffer. When no frame is waiting, the line carries back-to-back flags, so a receiver can always find octet boundaries. NRZI coding and aborts belong to the neighbouring logic.

Top module: `hdlc_tx_stuffer`

## Requirements
- R1: With no frame pending, the output carries back-to-back flags. A flag is the octet 0x7E sent least significant bit first, which gives the slot sequence 0,1,1,1,1,1,1,0.
- R2: Inside the data and check-sequence fields, a 0 is inserted in the slot after every run of five consecutive 1 bits. That slot stalls the byte shifter, and the run count starts again from zero after it. No more than five 1 bits ever appear in a row outside a flag.
- R3: Flags are never stuffed, and the run count is cleared at the end of each flag. If the check sequence ends in five 1 bits, the owed 0 is sent before the closing flag.
- R4: Data bytes are sent least significant bit first, in the order they were accepted.
- R5: The frame check sequence is the ones complement of the CRC-16 with polynomial x^16+x^12+x^5+1. The CRC is computed bit-serially in reflected form (constant 0x8408), preset to 0xFFFF, over all data bits. It is sent low-order bit first, low byte first.
- R6: The byte flagged as last is followed by exactly two check-sequence bytes and then a flag. That flag may also open the next frame, so every frame lies between two flags.
- R7: `txBit` changes only at a clock edge where `bitEn` is high.
- R8: `inReady` drops in the cycle after a byte is accepted. It rises again once that byte has moved from the one-byte holding stage into the shifter. A byte that is ready before its predecessor finishes follows it with no gap.
- R9: During reset, `txBit` is 1 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-slot enable; one output bit per cycle with this high |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Holding stage can take a byte |
| txBit | output | 1 | Serial line output |

## Verification
The output is decoded by a receiver model in the bench. The model finds flags, removes stuffed zeros, splits frames and checks each byte and the check sequence against a CRC computed in the bench. Frames of all-ones bytes force stuffing at many points and across byte boundaries. Frames made of the flag byte 0x7E show that data can never be mistaken for a flag. Single-byte frames, all-zero frames and random frames of random length cover the short and typical cases. A sparse random bit enable is mixed with a bit enable held high, which separates stalls caused by stuffing from stalls caused by a slow bit clock. The idle period and the back-to-back frames show how flags are shared between frames.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int DATA_W    = 8;
  localparam int FCS_W     = 16;
  localparam int STUFF_RUN = 5;
  localparam logic [DATA_W-1:0] FLAG_PAT   = 8'h7E;
  localparam logic [FCS_W-1:0]  CRC_POLY_R = 16'h8408;
  localparam logic [FCS_W-1:0]  CRC_PRESET = 16'hFFFF;

  typedef enum logic [1:0] {PH_FLAG, PH_DATA, PH_FCS} phase_t;

  typedef struct packed {
    logic       stuffSlot;  // emit inserted zero
    logic       flagBit;    // emit flag bit at flagIdx
    logic       dataBit;    // emit shifter bit and shift
    logic       crcUpdate;  // fold current bit into CRC
    logic       crcInit;    // preset CRC
    logic       loadByte;   // move holding byte into shifter
    logic       loadFcs;    // move complemented CRC into shifter
    logic [2:0] flagIdx;
  } dp_strobe_t;

  function automatic logic [FCS_W-1:0] crcStep(input logic [FCS_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crcStep = (c >> 1) ^ (fb ? CRC_POLY_R : '0);
  endfunction
endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int CNT_W = $clog2(FCS_W),
  parameter int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             curBit,
  input  logic             holdValid,
  input  logic             holdLast,
  output dp_strobe_t       strb,
  output phase_t           phase,
  output logic [RUN_W-1:0] onesCnt
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_FCS  = CNT_W'(FCS_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(STUFF_RUN);

  logic [CNT_W-1:0] bitCnt;
  logic curLast;
  logic stuff, endFlag, dataAdv, endByte, endFcs;

  always_comb begin
    stuff   = bitEn && (onesCnt == RUN_MAX);
    endFlag = bitEn && !stuff && (phase == PH_FLAG) && (bitCnt == LAST_DATA);
    dataAdv = bitEn && !stuff && (phase != PH_FLAG);
    endByte = dataAdv && (phase == PH_DATA) && (bitCnt == LAST_DATA);
    endFcs  = dataAdv && (phase == PH_FCS) && (bitCnt == LAST_FCS);

    strb           = '0;
    strb.stuffSlot = stuff;
    strb.flagBit   = bitEn && !stuff && (phase == PH_FLAG);
    strb.dataBit   = dataAdv;
    strb.crcUpdate = dataAdv && (phase == PH_DATA);
    strb.crcInit   = endFlag && holdValid;
    strb.loadByte  = (endFlag && holdValid) || (endByte && !curLast && holdValid);
    strb.loadFcs   = endByte && (curLast || !holdValid);
    strb.flagIdx   = bitCnt[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_FLAG;
      bitCnt  <= '0;
      onesCnt <= '0;
      curLast <= 1'b0;
    end else begin
      if (stuff || endFlag) onesCnt <= '0;
      else if (dataAdv)     onesCnt <= curBit ? onesCnt + 1'b1 : '0;

      if (endFlag || endByte || endFcs) bitCnt <= '0;
      else if (bitEn && !stuff)         bitCnt <= bitCnt + 1'b1;

      if (strb.loadByte) curLast <= holdLast;

      if (endFlag)            phase <= holdValid ? PH_DATA : PH_FLAG;
      else if (strb.loadFcs)  phase <= PH_FCS;
      else if (endFcs)        phase <= PH_FLAG;
    end
  end
endmodule

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic              holdValid,
  output logic              holdLast,
  output logic              curBit,
  output logic              txBit
);
  logic [DATA_W-1:0] holdData;
  logic [FCS_W-1:0]  shReg;
  logic [FCS_W-1:0]  crc, crcNext;

  assign inReady = !holdValid;
  assign curBit  = shReg[0];
  assign crcNext = crcStep(crc, curBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdLast  <= 1'b0;
      holdData  <= '0;
    end else if (inValid && inReady) begin
      holdValid <= 1'b1;
      holdLast  <= inLast;
      holdData  <= inData;
    end else if (strb.loadByte) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      crc   <= CRC_PRESET;
      txBit <= 1'b1;
    end else begin
      if (strb.crcInit)        crc <= CRC_PRESET;
      else if (strb.crcUpdate) crc <= crcNext;

      if (strb.loadByte)     shReg <= {{(FCS_W-DATA_W){1'b0}}, holdData};
      else if (strb.loadFcs) shReg <= ~crcNext;
      else if (strb.dataBit) shReg <= shReg >> 1;

      if (strb.stuffSlot)    txBit <= 1'b0;
      else if (strb.flagBit) txBit <= FLAG_PAT[strb.flagIdx];
      else if (strb.dataBit) txBit <= curBit;
    end
  end
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [7:0] inData,
  input  logic       inLast,
  input  logic       inValid,
  output logic       inReady,
  output logic       txBit
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  dp_strobe_t       strb;
  phase_t           phase;
  logic [RUN_W-1:0] onesCnt;
  logic             curBit, holdValid, holdLast;

  hdlc_tx_ctrl #(.RUN_W(RUN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .curBit(curBit),
    .holdValid(holdValid), .holdLast(holdLast),
    .strb(strb), .phase(phase), .onesCnt(onesCnt)
  );

  hdlc_tx_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inLast(inLast),
    .inValid(inValid), .inReady(inReady), .holdValid(holdValid),
    .holdLast(holdLast), .curBit(curBit), .txBit(txBit)
  );
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker
  import hdlc_tx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       inValid,
  input logic       inReady,
  input logic       txBit,
  input phase_t     phase,
  input logic [2:0] onesCnt
);
  logic       sampleNow;
  logic [3:0] lineRun;

  // run of ones seen on the line, one step per emitted slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleNow <= 1'b0;
      lineRun   <= '0;
    end else begin
      sampleNow <= bitEn;
      if (sampleNow) lineRun <= txBit ? ((lineRun == 4'hF) ? lineRun : lineRun + 1'b1) : '0;
    end
  end

  assert_line_run_R2: assert property (@(posedge clk) disable iff (!rstN) lineRun <= 4'd6);
  assert_ones_cnt_R2: assert property (@(posedge clk) disable iff (!rstN) onesCnt <= 3'(STUFF_RUN));
  assert_fcs_to_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FCS) |=> (phase == PH_FCS || phase == PH_FLAG));
  assert_stable_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
endmodule

bind hdlc_tx_stuffer hdlc_tx_checker chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid), .inReady(inReady),
  .txBit(txBit), .phase(phase), .onesCnt(onesCnt)
);

// File: tb/hdlc_tx_stuffer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_stuffer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic inValid = 1'b0;
  logic inReady, txBit;

  always #2.5 clk = ~clk;

  hdlc_tx_stuffer dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inData(inData), .inLast(inLast),
    .inValid(inValid), .inReady(inReady), .txBit(txBit)
  );

  int checks = 0, failures = 0;
  int slotCnt = 0, flagCnt = 0, framesSeen = 0, framesSent = 0;
  bit enAlways = 1'b0, bitEnQ = 1'b0, hunting = 1'b1, finished = 1'b0;
  logic lastTx = 1'b1;
  int ones = 0;
  bit rxBits[$];
  logic [7:0] expBytes[$];
  int expLens[$];
  logic [7:0] frameBuf[16];

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic endFrame(input int n);
    logic [7:0] got[$];
    logic [15:0] c;
    int len;
    for (int i = 0; i < n / 8; i++) begin
      logic [7:0] b;
      for (int k = 0; k < 8; k++) b[k] = rxBits[i*8 + k];   // R4: LSB first
      got.push_back(b);
    end
    framesSeen++;
    checks++;
    if (expLens.size() == 0) begin fail("R6", "unexpected frame bits", n, 0); return; end
    len = expLens.pop_front();
    if (n != (len + 2) * 8) begin
      fail("R6", "frame bit count", n, (len + 2) * 8);
      for (int i = 0; i < len; i++) void'(expBytes.pop_front());
      return;
    end
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      logic [7:0] e;
      e = expBytes.pop_front();
      checks++;
      if (got[i] !== e) fail("R4", "data byte", got[i], e);
      c = refCrc(c, e);
    end
    c = ~c;
    checks++;
    if ({got[len+1], got[len]} !== c) fail("R5", "check sequence", {got[len+1], got[len]}, c);
  endtask

  task automatic decodeBit(input logic b);
    slotCnt++;
    if (b) begin
      ones++;
      if (ones >= 7 && !hunting) begin
        checks++;
        fail("R2", "ones run on line", ones, 6);
      end
      rxBits.push_back(1'b1);
    end else begin
      if (ones == 5) begin
        // stuffed zero dropped
      end else if (ones == 6) begin
        flagCnt++;
        if (!hunting && rxBits.size() > 7) endFrame(rxBits.size() - 7);
        hunting = 1'b0;
        rxBits.delete();
      end else begin
        rxBits.push_back(1'b0);
      end
      ones = 0;
    end
  endtask

  // line sampling and bit-enable generation at the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (bitEnQ) decodeBit(txBit);
      else begin
        checks++;
        if (txBit !== lastTx) fail("R7", "txBit moved without bitEn", txBit, lastTx);
      end
    end
    lastTx = txBit;
    bitEn  = rstN && (enAlways || ($urandom % 3 == 0));
    bitEnQ = bitEn;
  end

  task automatic putByte(input logic [7:0] d, input logic l);
    inData = d; inLast = l; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (inReady !== 1'b0) fail("R8", "inReady after accept", inReady, 0);
  endtask

  task automatic sendFrame(input int len);
    expLens.push_back(len);
    for (int i = 0; i < len; i++) expBytes.push_back(frameBuf[i]);
    framesSent++;
    for (int i = 0; i < len; i++) putByte(frameBuf[i], i == len - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fail("WDOG", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    checks++; if (txBit !== 1'b1)  fail("R9", "txBit in reset", txBit, 1);
    checks++; if (inReady !== 1'b1) fail("R9", "inReady in reset", inReady, 1);
    rstN = 1'b1;

    // R1: idle line carries only flags
    wait (slotCnt >= 64);
    @(negedge clk);
    checks++; if (flagCnt < 6) fail("R1", "idle flag count", flagCnt, 6);
    checks++; if (framesSeen != 0) fail("R1", "frames while idle", framesSeen, 0);

    // R2 / R3: all-ones frames stress stuffing across byte and FCS boundaries
    for (int i = 0; i < 6; i++) frameBuf[i] = 8'hFF;
    sendFrame(6);
    frameBuf[0] = 8'h7E; frameBuf[1] = 8'h7E; frameBuf[2] = 8'h7E;
    sendFrame(3);
    frameBuf[0] = 8'h00; sendFrame(1);
    frameBuf[0] = 8'hF8; frameBuf[1] = 8'h1F; frameBuf[2] = 8'hFF; frameBuf[3] = 8'h3E;
    sendFrame(4);

    enAlways = 1'b1;
    for (int i = 0; i < 4; i++) frameBuf[i] = 8'hFF;
    sendFrame(4);
    frameBuf[0] = 8'hA5; sendFrame(1);
    enAlways = 1'b0;

    for (int f = 0; f < 24; f++) begin
      int len;
      len = 1 + ($urandom % 12);
      for (int i = 0; i < len; i++) frameBuf[i] = 8'($urandom);
      if (f % 5 == 0) frameBuf[len-1] = 8'hFF;
      enAlways = (f % 4 == 3);
      sendFrame(len);
      if ($urandom % 2 == 0) repeat ($urandom % 60) @(negedge clk);
    end
    enAlways = 1'b0;

    wait (framesSeen >= framesSent);
    repeat (40) @(negedge clk);
    checks++; if (framesSeen != framesSent) fail("R6", "frame count", framesSeen, framesSent);
    checks++; if (expLens.size() != 0) fail("R6", "frames not closed", expLens.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule